// File: doc/BRIEF.md
# Stepped-Frequency Sine Excitation Source

This block produces a digital sine wave for a 14-bit parallel DAC. It is meant for impedance and frequency-response measurement. Each clock, a phase register adds a tuning word. The upper bits of the phase address a sine table, and every clock one registered sample goes to the DAC pins.

The block has two modes. In hold mode it plays one frequency, which software sets by driving a tuning word. In sweep mode it waits for a start pulse and then steps through a fixed number of frequencies. The first step is 0 Hz. Each later step adds a programmable increment word to the tuning word, so no multiplier is needed. Each step lasts a programmable number of clock cycles.

A one-cycle step strobe and a step index mark the start of each step, so that capture logic can line its windows up with the excitation. A one-cycle done pulse follows the last step.

Top module: `dds_sweep_gen`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, `dacSample` is mid-scale 8192, and `stepStrobe`, `sweepDone` and `stepIndex` are all 0.
- R2: `dacSample` in a cycle equals the table entry 8192 + round(8191 * sin(2*pi*a/1024)). Here a is bits 31..22 of the 32-bit phase register in the previous cycle.
- R3: In hold mode (`modeSweep` = 0, no sweep running), the tuning word in use in cycle n+1 is the `fixedTuning` value presented in cycle n. The phase register adds the tuning word in use every clock.
- R4: In sweep mode (`modeSweep` = 1) with no sweep running, phase and tuning word are held at 0. `dacSample` therefore stays at the mid-scale 8192.
- R5: A `startSweep` pulse is accepted only in sweep mode with no sweep running. In hold mode, or while a sweep runs, it produces no strobe and no change of `stepIndex`.
- R6: A sweep has 11 steps, k = 0..10, and step k uses tuning word k * `incWord`. Step 0 (0 Hz) outputs a constant 8192, because the phase is cleared at the start.
- R7: `stepStrobe` is high for exactly one cycle as each step becomes active, which is the cycle after the edge that starts it. In that cycle `stepIndex` shows k. Successive strobes are `dwellCycles` cycles apart.
- R8: A `dwellCycles` of 0 behaves as 1, so a step then lasts one cycle.
- R9: `sweepDone` is a single-cycle pulse. It comes `dwellCycles` cycles after the strobe of the last step, and `stepIndex` is 10 at that time. Afterwards the block is idle in whichever mode `modeSweep` selects.
- R10: A change of `modeSweep` during a sweep does not cut the sweep short. The mode takes effect after `sweepDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSweep | input | 1 | 1 = sweep mode, 0 = hold mode |
| startSweep | input | 1 | Start request for a sweep |
| fixedTuning | input | 32 | Tuning word used in hold mode |
| incWord | input | 32 | Tuning increment between sweep steps |
| dwellCycles | input | 24 | Clock cycles per sweep step (0 acts as 1) |
| dacSample | output | 14 | Registered unsigned sample for the DAC |
| stepStrobe | output | 1 | One-cycle pulse at the start of each step |
| sweepDone | output | 1 | One-cycle pulse after the last step |
| stepIndex | output | 4 | Index of the current or last step |

## Verification
A cycle-level reference model feeds a scoreboard, and the bench drives the block through several patterns.

Hold mode is tried with a tuning word of exactly three table addresses per clock. That word visits every entry of the table, so it separates a wrong table or a wrong address slice from a correct one. A second hold word has low-order bits set, and it shows whether the fractional carries reach the address.

Sweep runs use a dwell of seven cycles, a dwell of zero and a dwell of two. They separate correct strobe spacing, step counting and done timing from off-by-one errors, and they check that 0 means one cycle. One sweep is disturbed by a start pulse and by a drop to hold mode partway through, which shows that both are ignored until the sweep ends. A start pulse given in hold mode shows that it is rejected.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Strobes from the sweep controller to the datapath
  typedef struct packed {
    logic clearPhase;
    logic clearTuning;
    logic loadFixed;
    logic addIncrement;
  } dpCtrl_t;

  // Table entry: mid-scale plus a sine of amplitude mid-scale minus one
  function automatic int sineCode(int idx, int depth, int dataW);
    int  mid;
    real amp;
    mid = 1 << (dataW - 1);
    amp = real'(mid - 1);
    return mid + $rtoi($floor(amp * $sin(6.283185307179586 * real'(idx) / real'(depth)) + 0.5));
  endfunction

endpackage

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtrl_t            ctrl,
  input  logic [PHASE_W-1:0] fixedTuning,
  input  logic [PHASE_W-1:0] incWord,
  output logic [DATA_W-1:0]  dacSample
);

  localparam int ROM_DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]  sineRom [ROM_DEPTH];
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] tuningReg;
  logic [ADDR_W-1:0]  romAddr;

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++)
      sineRom[i] = DATA_W'(sineCode(i, ROM_DEPTH, DATA_W));
  end

  assign romAddr = phase[PHASE_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      tuningReg <= '0;
      dacSample <= MID_CODE;
    end else begin
      dacSample <= sineRom[romAddr];
      phase     <= ctrl.clearPhase ? '0 : phase + tuningReg;
      if (ctrl.clearTuning)       tuningReg <= '0;
      else if (ctrl.loadFixed)    tuningReg <= fixedTuning;
      else if (ctrl.addIncrement) tuningReg <= tuningReg + incWord;
    end
  end

  // R4: idle sweep mode pins the phase at zero
  assert_phase_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.clearPhase |=> phase == '0);

  // R3: hold mode takes the presented word on the next cycle
  assert_fixed_loaded_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadFixed |=> tuningReg == $past(fixedTuning));

  // R6: each step advances the tuning word by one increment
  assert_step_increment_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.addIncrement |=> tuningReg == $past(tuningReg) + $past(incWord));

  // R2: address zero yields the mid-scale code one cycle later
  assert_zero_phase_mid_R2: assert property (@(posedge clk) disable iff (rst)
    (romAddr == '0) |=> dacSample == MID_CODE);

endmodule

// File: rtl/dds_sweep_ctrl.sv
module dds_sweep_ctrl
  import dds_pkg::*;
#(
  parameter int NUM_STEPS = 11,
  parameter int DWELL_W   = 24,
  parameter int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               modeSweep,
  input  logic               startSweep,
  input  logic [DWELL_W-1:0] dwellCycles,
  output dpCtrl_t            dpCtrl,
  output logic               stepStrobe,
  output logic               sweepDone,
  output logic [STEP_W-1:0]  stepIndex
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic               sweeping;
  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] dwellLoad;
  logic               idle, startGo, dwellDone, lastStep;

  assign idle      = !sweeping;
  assign startGo   = idle && modeSweep && startSweep;
  assign dwellDone = sweeping && (dwellCnt == '0);
  assign lastStep  = (stepIndex == LAST_STEP);
  assign dwellLoad = (dwellCycles == '0) ? '0 : dwellCycles - DWELL_W'(1);

  always_comb begin
    dpCtrl.clearPhase   = idle && modeSweep;
    dpCtrl.clearTuning  = (idle && modeSweep) || (dwellDone && lastStep);
    dpCtrl.loadFixed    = idle && !modeSweep;
    dpCtrl.addIncrement = dwellDone && !lastStep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping   <= 1'b0;
      dwellCnt   <= '0;
      stepIndex  <= '0;
      stepStrobe <= 1'b0;
      sweepDone  <= 1'b0;
    end else begin
      stepStrobe <= 1'b0;
      sweepDone  <= 1'b0;
      if (startGo) begin
        sweeping   <= 1'b1;
        stepIndex  <= '0;
        dwellCnt   <= dwellLoad;
        stepStrobe <= 1'b1;
      end else if (dwellDone) begin
        if (lastStep) begin
          sweeping  <= 1'b0;
          sweepDone <= 1'b1;
        end else begin
          stepIndex  <= stepIndex + STEP_W'(1);
          dwellCnt   <= dwellLoad;
          stepStrobe <= 1'b1;
        end
      end else if (sweeping) begin
        dwellCnt <= dwellCnt - DWELL_W'(1);
      end
    end
  end

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    sweepDone |=> !sweepDone);

  // R9: done arrives only after the last step
  assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
    sweepDone |-> stepIndex == LAST_STEP);

  // R6: the index never passes the last step
  assert_index_bound_R6: assert property (@(posedge clk) disable iff (rst)
    stepIndex <= LAST_STEP);

  // R7: a strobe past step 0 shows the next index in order
  assert_strobe_order_R7: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe && stepIndex != '0) |-> stepIndex == $past(stepIndex) + STEP_W'(1));

  // R5: a start request mid-dwell does not restart the sweep
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (sweeping && startSweep && dwellCnt != '0) |=> !stepStrobe);

endmodule

// File: rtl/dds_sweep_gen.sv
module dds_sweep_gen
  import dds_pkg::*;
#(
  parameter int PHASE_W   = 32,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 14,
  parameter int DWELL_W   = 24,
  parameter int NUM_STEPS = 11,
  parameter int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               modeSweep,
  input  logic               startSweep,
  input  logic [PHASE_W-1:0] fixedTuning,
  input  logic [PHASE_W-1:0] incWord,
  input  logic [DWELL_W-1:0] dwellCycles,
  output logic [DATA_W-1:0]  dacSample,
  output logic               stepStrobe,
  output logic               sweepDone,
  output logic [STEP_W-1:0]  stepIndex
);

  dpCtrl_t dpCtrl;

  dds_sweep_ctrl #(
    .NUM_STEPS(NUM_STEPS),
    .DWELL_W  (DWELL_W),
    .STEP_W   (STEP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .modeSweep  (modeSweep),
    .startSweep (startSweep),
    .dwellCycles(dwellCycles),
    .dpCtrl     (dpCtrl),
    .stepStrobe (stepStrobe),
    .sweepDone  (sweepDone),
    .stepIndex  (stepIndex)
  );

  dds_datapath #(
    .PHASE_W(PHASE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (dpCtrl),
    .fixedTuning(fixedTuning),
    .incWord    (incWord),
    .dacSample  (dacSample)
  );

endmodule

// File: tb/tb_dds_sweep_gen.sv
module tb_dds_sweep_gen;

  localparam int NS  = 11;
  localparam int MID = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeSweep = 1'b0;
  logic        startSweep = 1'b0;
  logic [31:0] fixedTuning = '0;
  logic [31:0] incWord = '0;
  logic [23:0] dwellCycles = '0;
  logic [13:0] dacSample;
  logic        stepStrobe;
  logic        sweepDone;
  logic [3:0]  stepIndex;

  dds_sweep_gen dut (
    .clk(clk), .rst(rst), .modeSweep(modeSweep), .startSweep(startSweep),
    .fixedTuning(fixedTuning), .incWord(incWord), .dwellCycles(dwellCycles),
    .dacSample(dacSample), .stepStrobe(stepStrobe), .sweepDone(sweepDone),
    .stepIndex(stepIndex)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string curTag = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refSine(int a);
    return MID + $rtoi($floor(8191.0 * $sin(6.283185307179586 * real'(a) / 1024.0) + 0.5));
  endfunction

  typedef struct {
    int sample;
    bit strobe;
    bit done;
    int idx;
  } expItem_t;
  expItem_t expQ[$];

  // Reference model built from the requirements; pushes the values expected after each edge
  logic [31:0] mPhase, mTune, nPhase, nTune;
  bit mSweep, mIdle, mGo, mExpire, mLast, nStrobe, nDone;
  int mIdx, mDwell, nIdx, nDwell, dLoad;

  always @(posedge clk) begin
    if (rst) begin
      mPhase = '0; mTune = '0; mSweep = 0; mIdx = 0; mDwell = 0;
    end else begin
      mIdle   = !mSweep;
      mGo     = mIdle && modeSweep && startSweep;
      mExpire = mSweep && (mDwell == 0);
      mLast   = (mIdx == NS - 1);
      dLoad   = (dwellCycles == 0) ? 0 : int'(dwellCycles) - 1;
      nPhase  = (mIdle && modeSweep) ? 32'd0 : mPhase + mTune;
      if (mIdle && !modeSweep)                        nTune = fixedTuning;
      else if ((mIdle && modeSweep) || (mExpire && mLast)) nTune = '0;
      else if (mExpire)                               nTune = mTune + incWord;
      else                                            nTune = mTune;
      nStrobe = 0; nDone = 0; nIdx = mIdx; nDwell = mDwell;
      if (mGo) begin
        mSweep = 1; nIdx = 0; nDwell = dLoad; nStrobe = 1;
      end else if (mExpire) begin
        if (mLast) begin mSweep = 0; nDone = 1; end
        else begin nIdx = mIdx + 1; nDwell = dLoad; nStrobe = 1; end
      end else if (mSweep) begin
        nDwell = mDwell - 1;
      end
      expQ.push_back('{refSine(int'(mPhase[31:22])), nStrobe, nDone, nIdx});
      mPhase = nPhase; mTune = nTune; mIdx = nIdx; mDwell = nDwell;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      chk(int'(dacSample) == e.sample, curTag, "dacSample", int'(dacSample), e.sample);
      chk(stepStrobe == e.strobe, "R7", "stepStrobe", int'(stepStrobe), int'(e.strobe));
      chk(sweepDone == e.done, "R9", "sweepDone", int'(sweepDone), int'(e.done));
      chk(int'(stepIndex) == e.idx, "R7", "stepIndex", int'(stepIndex), e.idx);
    end
  end

  task automatic runSweep(logic [31:0] inc, logic [23:0] dwell, bit disturb);
    int strobes = 0;
    int lastStrobe = 0;
    int dones = 0;
    int gap;
    gap = (dwell == 0) ? 1 : int'(dwell);
    incWord = inc;
    dwellCycles = dwell;
    startSweep = 1'b1;
    @(negedge clk);
    startSweep = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      startSweep = 1'b0;
      if (stepStrobe) begin
        chk(int'(stepIndex) == strobes, "R7", "index at strobe", int'(stepIndex), strobes);
        if (strobes > 0)
          chk(cyc - lastStrobe == gap, (dwell == 0) ? "R8" : "R7", "strobe gap", cyc - lastStrobe, gap);
        lastStrobe = cyc;
        strobes++;
        if (disturb && strobes == 3) startSweep = 1'b1;  // R5: start while sweeping
        if (disturb && strobes == 5) modeSweep = 1'b0;   // R10: mode drop mid-sweep
      end else if (strobes == 1 && stepIndex == 0) begin
        chk(int'(dacSample) == MID, "R6", "0 Hz step sample", int'(dacSample), MID);
      end
      if (sweepDone) begin
        dones++;
        chk(cyc - lastStrobe == gap, "R9", "done delay", cyc - lastStrobe, gap);
        chk(int'(stepIndex) == NS - 1, "R9", "index at done", int'(stepIndex), NS - 1);
        break;
      end
      @(negedge clk);
    end
    chk(strobes == NS, disturb ? "R10" : "R7", "strobe count", strobes, NS);
    chk(dones == 1, "R9", "done count", dones, 1);
    @(negedge clk);
    chk(!sweepDone, "R9", "done after pulse", int'(sweepDone), 0);
  endtask

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(dacSample) == MID, "R1", "reset sample", int'(dacSample), MID);
    chk(!stepStrobe, "R1", "reset strobe", int'(stepStrobe), 0);
    chk(!sweepDone, "R1", "reset done", int'(sweepDone), 0);
    chk(stepIndex == 0, "R1", "reset index", int'(stepIndex), 0);
    rst = 1'b0;

    curTag = "R2 R3";
    fixedTuning = 32'd3 << 22;
    repeat (1100) @(negedge clk);
    fixedTuning = 32'h1234_5679;
    repeat (300) @(negedge clk);

    curTag = "R5";
    startSweep = 1'b1;
    @(negedge clk);
    startSweep = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      seen |= stepStrobe;
      @(negedge clk);
    end
    chk(!seen, "R5", "strobe in hold mode", int'(seen), 0);
    chk(stepIndex == 0, "R5", "index in hold mode", int'(stepIndex), 0);

    curTag = "R4";
    modeSweep = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk(int'(dacSample) == MID, "R4", "idle sweep sample", int'(dacSample), MID);
      @(negedge clk);
    end

    curTag = "R6";
    runSweep(32'd5 << 22, 24'd7, 1'b1);
    curTag = "R10";
    fixedTuning = 32'h0ABC_DEF1;
    repeat (50) @(negedge clk);

    modeSweep = 1'b1;
    repeat (5) @(negedge clk);
    curTag = "R8";
    runSweep(32'h0123_4567, 24'd0, 1'b0);
    repeat (5) @(negedge clk);
    curTag = "R6";
    runSweep(32'h0290_0000, 24'd2, 1'b0);
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule